// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a dual-plane NOR flash model. It watches an asynchronous chip-enable / write-enable / output-enable bus, brings the strobes into the system clock domain, and rebuilds each bus write cycle from them. Each completed write is fed to a sequence decoder. The decoder recognises the multi-cycle unlock sequences for these functions: word program, sector erase, chip erase, sector lock, fast-program mode entry, and identification mode entry and exit.

When a sequence finishes, the block issues a one-cycle start request to the internal operation engine. The request carries the operation kind, the latched address and data, and the set of sectors to skip. Sector lock bits are kept here. A request aimed at a locked sector is turned into a refusal pulse unless the high-voltage override input is asserted.

In fast-program mode, every single write cycle is a program request. Codes that would otherwise start an erase or a suspend are passed on as program data. Only a reset leaves this mode. All unlock addresses and code values are parameters.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While and after reset, `start_o` and `refuse_o` are 0. `bypass_o` and `id_mode_o` are 0, and every bit of `lock_o` is 0.
- R2: A write cycle is the interval in which CE, WE and OE are low, low and high. The address is taken when that interval begins, at the later of the CE and WE falling edges. The data is taken when it ends, at the first rising edge of either strobe. Later changes of the address or data bus have no effect on that cycle.
- R3: Four write cycles (0xAA at UNLOCK_A1, 0x55 at UNLOCK_A2, 0xA0 at UNLOCK_A1, then any address and data) give one `start_o` pulse with `op_o`=0 (program). The pulse carries the fourth cycle's address and full 16-bit data.
- R4: Six write cycles (AA@A1, 55@A2, 0x80@A1, AA@A1, 55@A2, then 0x30 at any address) give `start_o` with `op_o`=1 (sector erase). `op_addr_o` is the sixth cycle's address. The sector number is address bits [ADDR_W-1 -: log2(NUM_SECT)].
- R5: The same six cycles ending with 0x10 at A1 give `start_o` with `op_o`=2 (chip erase). `skip_mask_o` equals the locked sectors, or is all zero when `hv_override_i` is 1.
- R6: Only data bits [7:0] are compared against command codes. Bits [15:8] of command cycles have no effect.
- R7: A write that does not match the expected step of a sequence returns the decoder to idle, so the remaining steps do not complete that sequence.
- R8: The six-cycle sequence ending with 0x40 at any address sets the lock bit of that address's sector, visible on `lock_o`. Lock bits are cleared only by reset.
- R9: A program or sector erase whose target sector is locked gives a `refuse_o` pulse and no `start_o`, unless `hv_override_i` is 1. With the override, it gives a normal start.
- R10: The six-cycle sequence ending with 0x20 at A1 sets `bypass_o`. After that, every single write cycle gives a program request for its own address and data.
- R11: In fast-program mode, writes with codes 0x80, 0x30 or 0xB0 are program requests with that data. `bypass_o` stays 1 until `rst_ni` is asserted.
- R12: A write cycle that ends while `busy_i` is 1 is ignored. It makes no request and leaves the sequence position unchanged.
- R13: Three cycles AA@A1, 55@A2, 0x90@A1 set `id_mode_o`. The same three cycles with 0xF0 clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| busy_i | input | 1 | Operation engine is running |
| hv_override_i | input | 1 | Lock override is active |
| start_o | output | 1 | One-cycle operation start |
| op_o | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| op_addr_o | output | ADDR_W | Address of the request |
| op_data_o | output | DATA_W | Data of the request |
| skip_mask_o | output | NUM_SECT | Sectors a chip erase must leave alone |
| refuse_o | output | 1 | One-cycle refusal of a request on a locked sector |
| lock_o | output | NUM_SECT | Sector lock bits |
| bypass_o | output | 1 | Fast-program mode is active |
| id_mode_o | output | 1 | Identification mode is active |

## Verification
Two things can fall in the same clock cycle: a write cycle completing, which the decoder would act on, and the operation engine reporting busy, which must suppress it. The bench provokes this by raising `busy_i` before a write's strobes rise and lowering it afterwards, both in the middle of a program sequence and at the first unlock cycle. The collision is judged at the ports. No start or refusal may appear. Then a single further write, with busy low, must complete the interrupted program sequence, which shows that the sequence position was neither advanced nor reset.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_PDATA,
    ST_E0,
    ST_E1,
    ST_E2
  } seq_e;
endpackage

// File: rtl/fcd_bus_sync.sv
module fcd_bus_sync #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  // bit 0 ce, bit 1 we, bit 2 oe
  logic [2:0] stg_q [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 3'b111;
      else if (g == 0) stg_q[g] <= {oe_ni, we_ni, ce_ni};
      else stg_q[g] <= stg_q[g-1];
    end
  end

  logic [2:0] s;
  logic act, act_q;
  assign s   = stg_q[SYNC_STAGES-1];
  assign act = ~s[0] & ~s[1] & s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      act_q <= act;
      wr_o  <= act_q & ~act;
      if (act & ~act_q) addr_o <= addr_i;
      if (act_q & ~act) data_o <= data_i;
    end
  end
endmodule

// File: rtl/fcd_lock_table.sv
module fcd_lock_table #(
  parameter int NUM_SECT = 8,
  localparam int SECT_W = $clog2(NUM_SECT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [SECT_W-1:0]   idx_i,
  output logic [NUM_SECT-1:0] lock_o
);
  for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lock_o[g] <= 1'b0;
      else if (set_i && idx_i == SECT_W'(g)) lock_o[g] <= 1'b1;
    end
  end

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~lock_o & $past(lock_o)) == '0)
    else $error("lock bit cleared without reset");
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int NUM_SECT = 8,
  parameter logic [ADDR_W-1:0] UNLOCK_A1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_A2 = 'h2AA,
  parameter logic [7:0] KEY1 = 8'hAA,
  parameter logic [7:0] KEY2 = 8'h55,
  parameter logic [7:0] C_PROG = 8'hA0,
  parameter logic [7:0] C_ERASE = 8'h80,
  parameter logic [7:0] C_ID_IN = 8'h90,
  parameter logic [7:0] C_ID_OUT = 8'hF0,
  parameter logic [7:0] C_CHIP = 8'h10,
  parameter logic [7:0] C_SECT = 8'h30,
  parameter logic [7:0] C_LOCK = 8'h40,
  parameter logic [7:0] C_BYPASS = 8'h20,
  localparam int SECT_W = $clog2(NUM_SECT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                busy_i,
  input  logic                hv_i,
  input  logic [NUM_SECT-1:0] lock_i,
  output logic                start_o,
  output logic                refuse_o,
  output logic [1:0]          op_o,
  output logic [ADDR_W-1:0]   op_addr_o,
  output logic [DATA_W-1:0]   op_data_o,
  output logic [NUM_SECT-1:0] skip_o,
  output logic                lock_set_o,
  output logic [SECT_W-1:0]   lock_idx_o,
  output logic                bypass_o,
  output logic                id_mode_o
);
  seq_e state_q, state_d;
  op_e  op_q, req_op;
  logic req, ok, go, at1, at2, bypass_d, id_d;
  logic [7:0] d8;
  logic [SECT_W-1:0] sect;

  assign go   = wr_i & ~busy_i;
  assign d8   = data_i[7:0];
  assign at1  = addr_i == UNLOCK_A1;
  assign at2  = addr_i == UNLOCK_A2;
  assign sect = addr_i[ADDR_W-1 -: SECT_W];
  assign ok   = (req_op == OP_CERASE) | ~lock_i[sect] | hv_i;
  assign lock_idx_o = sect;

  always_comb begin
    state_d    = state_q;
    bypass_d   = bypass_o;
    id_d       = id_mode_o;
    req        = 1'b0;
    req_op     = OP_PROG;
    lock_set_o = 1'b0;
    if (go) begin
      if (bypass_o) begin
        req = 1'b1;
      end else begin
        state_d = ST_IDLE;
        unique case (state_q)
          ST_IDLE: if (at1 && d8 == KEY1) state_d = ST_K1;
          ST_K1:   if (at2 && d8 == KEY2) state_d = ST_K2;
          ST_K2: if (at1) begin
            if (d8 == C_PROG) state_d = ST_PDATA;
            else if (d8 == C_ERASE) state_d = ST_E0;
            else if (d8 == C_ID_IN) id_d = 1'b1;
            else if (d8 == C_ID_OUT) id_d = 1'b0;
          end
          ST_PDATA: req = 1'b1;
          ST_E0: if (at1 && d8 == KEY1) state_d = ST_E1;
          ST_E1: if (at2 && d8 == KEY2) state_d = ST_E2;
          ST_E2: begin
            if (d8 == C_SECT) begin
              req = 1'b1; req_op = OP_SERASE;
            end else if (at1 && d8 == C_CHIP) begin
              req = 1'b1; req_op = OP_CERASE;
            end else if (d8 == C_LOCK) begin
              lock_set_o = 1'b1;
            end else if (at1 && d8 == C_BYPASS) begin
              bypass_d = 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bypass_o  <= 1'b0;
      id_mode_o <= 1'b0;
      start_o   <= 1'b0;
      refuse_o  <= 1'b0;
      op_q      <= OP_PROG;
      op_addr_o <= '0;
      op_data_o <= '0;
      skip_o    <= '0;
    end else begin
      state_q   <= state_d;
      bypass_o  <= bypass_d;
      id_mode_o <= id_d;
      start_o   <= req & ok;
      refuse_o  <= req & ~ok;
      if (req) begin
        op_q      <= req_op;
        op_addr_o <= addr_i;
        op_data_o <= data_i;
        skip_o    <= hv_i ? '0 : lock_i;
      end
    end
  end

  assign op_o = op_q;

  assert_start_xor_refuse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && refuse_o))
    else $error("start and refuse together");
  assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o)
    else $error("start longer than one cycle");
  assert_bypass_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(bypass_o))
    else $error("bypass left without reset");
  assert_busy_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> (!start_o && !refuse_o && $stable(state_q) && $stable(bypass_o)))
    else $error("write acted on while busy");
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int NUM_SECT = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] UNLOCK_A1 = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_A2 = 'h2AA,
  parameter logic [7:0] KEY1 = 8'hAA,
  parameter logic [7:0] KEY2 = 8'h55,
  parameter logic [7:0] C_PROG = 8'hA0,
  parameter logic [7:0] C_ERASE = 8'h80,
  parameter logic [7:0] C_ID_IN = 8'h90,
  parameter logic [7:0] C_ID_OUT = 8'hF0,
  parameter logic [7:0] C_CHIP = 8'h10,
  parameter logic [7:0] C_SECT = 8'h30,
  parameter logic [7:0] C_LOCK = 8'h40,
  parameter logic [7:0] C_BYPASS = 8'h20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ce_ni,
  input  logic                we_ni,
  input  logic                oe_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                busy_i,
  input  logic                hv_override_i,
  output logic                start_o,
  output logic [1:0]          op_o,
  output logic [ADDR_W-1:0]   op_addr_o,
  output logic [DATA_W-1:0]   op_data_o,
  output logic [NUM_SECT-1:0] skip_mask_o,
  output logic                refuse_o,
  output logic [NUM_SECT-1:0] lock_o,
  output logic                bypass_o,
  output logic                id_mode_o
);
  localparam int SECT_W = $clog2(NUM_SECT);

  logic              wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              lock_set;
  logic [SECT_W-1:0] lock_idx;

  fcd_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_o(wr), .addr_o(wr_addr), .data_o(wr_data)
  );

  fcd_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SECT(NUM_SECT),
    .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2), .KEY1(KEY1), .KEY2(KEY2),
    .C_PROG(C_PROG), .C_ERASE(C_ERASE), .C_ID_IN(C_ID_IN), .C_ID_OUT(C_ID_OUT),
    .C_CHIP(C_CHIP), .C_SECT(C_SECT), .C_LOCK(C_LOCK), .C_BYPASS(C_BYPASS)
  ) u_fsm (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(wr_addr), .data_i(wr_data),
    .busy_i, .hv_i(hv_override_i), .lock_i(lock_o),
    .start_o, .refuse_o, .op_o, .op_addr_o, .op_data_o, .skip_o(skip_mask_o),
    .lock_set_o(lock_set), .lock_idx_o(lock_idx), .bypass_o, .id_mode_o
  );

  fcd_lock_table #(.NUM_SECT(NUM_SECT)) u_lock (
    .clk_i, .rst_ni, .set_i(lock_set), .idx_i(lock_idx), .lock_o
  );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam logic [18:0] A1 = 19'h00555, A2 = 19'h002AA;

  logic clk = 0, rst_ni = 0, ce_ni = 1, we_ni = 1, oe_ni = 1;
  logic [18:0] addr = '0;
  logic [15:0] data = '0;
  logic busy = 0, hv = 0;
  logic start, refuse, bypass, id_mode;
  logic [1:0] op;
  logic [18:0] op_addr;
  logic [15:0] op_data;
  logic [7:0] skip, lock;

  int n_chk = 0, n_fail = 0, n_start = 0, n_refuse = 0;
  logic [1:0] l_op; logic [18:0] l_addr; logic [15:0] l_data; logic [7:0] l_skip;
  bit done = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i(addr), .data_i(data),
    .busy_i(busy), .hv_override_i(hv), .start_o(start), .op_o(op),
    .op_addr_o(op_addr), .op_data_o(op_data), .skip_mask_o(skip), .refuse_o(refuse),
    .lock_o(lock), .bypass_o(bypass), .id_mode_o(id_mode)
  );

  always @(negedge clk) begin
    if (rst_ni && start) begin
      n_start++; l_op = op; l_addr = op_addr; l_data = op_data; l_skip = skip;
    end
    if (rst_ni && refuse) n_refuse++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [18:0] a, logic [15:0] d);
    @(negedge clk); addr = a; data = d; ce_ni = 0;
    repeat (2) @(negedge clk); we_ni = 0;
    repeat (5) @(negedge clk); we_ni = 1;
    repeat (5) @(negedge clk); ce_ni = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock(); wr(A1, 16'h00AA); wr(A2, 16'h0055); endtask
  task automatic six(logic [18:0] a, logic [15:0] d);
    unlock(); wr(A1, 16'h0080); unlock(); wr(a, d);
  endtask

  task automatic t_reset();
    chk("R1 start", start, 0); chk("R1 refuse", refuse, 0);
    chk("R1 bypass", bypass, 0); chk("R1 id", id_mode, 0); chk("R1 lock", lock, 0);
  endtask

  task automatic t_capture();  // R2
    int s0 = n_start;
    unlock(); wr(A1, 16'h00A0);
    @(negedge clk); addr = 19'h01234; data = 16'h0000; we_ni = 0;
    repeat (3) @(negedge clk); ce_ni = 0;
    repeat (5) @(negedge clk); addr = 19'h07777;
    repeat (2) @(negedge clk); data = 16'h5A3C;
    repeat (2) @(negedge clk); we_ni = 1;
    repeat (5) @(negedge clk); data = 16'hFFFF; ce_ni = 1;
    repeat (4) @(negedge clk);
    chk("R2 count", n_start - s0, 1);
    chk("R2 addr", l_addr, 19'h01234);
    chk("R2 data", l_data, 16'h5A3C);
  endtask

  task automatic t_prog();  // R3
    int s0 = n_start;
    unlock(); wr(A1, 16'h00A0); wr(19'h04321, 16'hC0DE);
    chk("R3 count", n_start - s0, 1); chk("R3 op", l_op, 0);
    chk("R3 addr", l_addr, 19'h04321); chk("R3 data", l_data, 16'hC0DE);
  endtask

  task automatic t_upper();  // R6
    int s0 = n_start;
    wr(A1, 16'hFFAA); wr(A2, 16'h3C55); wr(A1, 16'h12A0); wr(19'h00040, 16'hBEEF);
    chk("R6 count", n_start - s0, 1); chk("R6 data", l_data, 16'hBEEF);
  endtask

  task automatic t_mismatch();  // R7
    int s0 = n_start;
    wr(A1, 16'h00AA); wr(19'h00123, 16'h0077); wr(A1, 16'h00A0); wr(19'h00100, 16'h5555);
    unlock(); wr(A1, 16'h0080); wr(A1, 16'h00AA); wr(A1, 16'h0055); wr(19'h10000, 16'h0030);
    chk("R7 no start", n_start - s0, 0);
    unlock(); wr(A1, 16'h00A0); wr(19'h00100, 16'h5555);
    chk("R7 recovers", n_start - s0, 1);
  endtask

  task automatic t_busy();  // R12
    int s0 = n_start; int r0 = n_refuse;
    unlock(); wr(A1, 16'h00A0);
    busy = 1; wr(19'h00200, 16'h1111); busy = 0;
    chk("R12 no start busy", n_start - s0, 0);
    wr(19'h00300, 16'h2222);
    chk("R12 state kept", n_start - s0, 1); chk("R12 data", l_data, 16'h2222);
    busy = 1; wr(A1, 16'h00AA); busy = 0;
    wr(A2, 16'h0055); wr(A1, 16'h00A0); wr(19'h00100, 16'h3333);
    chk("R12 unlock ignored", n_start - s0, 1);
    chk("R12 no refuse", n_refuse - r0, 0);
  endtask

  task automatic t_id();  // R13
    unlock(); wr(A1, 16'h0090); chk("R13 enter", id_mode, 1);
    unlock(); wr(A1, 16'h00F0); chk("R13 exit", id_mode, 0);
  endtask

  task automatic t_erase();  // R4, R5
    int s0 = n_start;
    six(19'h30777, 16'h0030);
    chk("R4 count", n_start - s0, 1); chk("R4 op", l_op, 1); chk("R4 addr", l_addr, 19'h30777);
    six(A1, 16'h0010);
    chk("R5 count", n_start - s0, 2); chk("R5 op", l_op, 2); chk("R5 skip none", l_skip, 0);
  endtask

  task automatic t_lock();  // R8, R9, R5
    int s0, r0;
    six(19'h20010, 16'h0040);
    chk("R8 lock bit", lock, 8'h04);
    s0 = n_start; r0 = n_refuse;
    unlock(); wr(A1, 16'h00A0); wr(19'h20100, 16'h0001);
    chk("R9 prog refused", n_refuse - r0, 1); chk("R9 prog no start", n_start - s0, 0);
    six(19'h20000, 16'h0030);
    chk("R9 erase refused", n_refuse - r0, 2); chk("R9 erase no start", n_start - s0, 0);
    hv = 1;
    unlock(); wr(A1, 16'h00A0); wr(19'h20100, 16'h0002);
    chk("R9 override start", n_start - s0, 1);
    six(A1, 16'h0010);
    chk("R5 override skip", l_skip, 0);
    hv = 0;
    six(A1, 16'h0010);
    chk("R5 skip locked", l_skip, 8'h04); chk("R5 op", l_op, 2);
    chk("R8 lock kept", lock, 8'h04);
  endtask

  task automatic t_bypass();  // R10, R11
    int s0;
    six(A1, 16'h0020);
    chk("R10 bypass on", bypass, 1);
    s0 = n_start;
    wr(19'h10000, 16'h0F0F);
    chk("R10 single write", n_start - s0, 1); chk("R10 addr", l_addr, 19'h10000);
    chk("R10 data", l_data, 16'h0F0F);
    wr(A1, 16'h0080); chk("R11 0x80 data", l_data, 16'h0080);
    wr(19'h11111, 16'h0030); chk("R11 0x30 data", l_data, 16'h0030); chk("R11 op", l_op, 0);
    wr(19'h00000, 16'h00B0); chk("R11 0xB0 data", l_data, 16'h00B0);
    chk("R11 count", n_start - s0, 4); chk("R11 still bypass", bypass, 1);
    @(negedge clk); rst_ni = 0; repeat (2) @(negedge clk); rst_ni = 1; @(negedge clk);
    chk("R11 reset clears", bypass, 0); chk("R1 lock after reset", lock, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1; @(negedge clk);
    t_reset();
    t_capture(); t_prog(); t_upper(); t_mismatch(); t_busy(); t_id();
    t_erase(); t_lock(); t_bypass();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule